// File: doc/BRIEF.md
# Programmable Address Window Remapper

This block translates request addresses from two independent sources, a processor-side port and a bus-master DMA port, into target addresses, and reports which destination each request goes to. Each source owns its own set of four windows. A window is described by three 64-bit registers: a match base, a match mask and a remap word. The remap word holds the translated base with a small destination code in its lowest bits. The code is 0 for DRAM, and 1 for the peripheral bus on the processor side or for local I/O on the DMA side.

Translation is combinational. For each source the block selects the lowest-numbered window whose masked base equals the masked request address. It replaces the masked upper bits with the translated base and keeps the offset bits below the mask. When no window matches, the address passes through unchanged and a miss flag is raised. A flat 64-bit register port programs all windows. Its combinational read returns the stored word.

From reset, two processor windows give a working boot map: the first 256 MiB go to DRAM and the next 256 MiB go to the peripheral bus. All other windows reset to all-ones base and all-ones mask, so in practice they are disabled.

Top module: `addrwin_remap`

## Requirements
- R1: After reset, processor window 0 has base 0, mask 0xFFFFFFFF_F0000000 and remap 0. Processor window 1 has base 0x10000000, the same mask, and remap 0x10000001. Addresses below 0x10000000 therefore translate to themselves with code 0, and addresses from 0x10000000 up to 0x1FFFFFFF translate to themselves with code 1.
- R2: After reset, every other window (processor 2–3, DMA 0–3) holds base and mask equal to all ones and remap equal to 0.
- R3: Register byte offsets are fixed. Processor base registers for windows w = 0..3 are at 0x00+8w, processor masks at 0x20+8w and processor remaps at 0x40+8w. DMA bases are at 0x60+8w, DMA masks at 0x80+8w and DMA remaps at 0xA0+8w. A read returns the last stored 64-bit word.
- R4: Offsets from 0xC0 upward read as zero, and writes to them change no register. Offset bits [2:0] are ignored.
- R5: A window hits when (addr & mask) == (base & mask).
- R6: On a hit, the output address is (remap & mask & ~7) | (addr & ~mask). The 3 code bits never reach the address.
- R7: On a hit, the target output equals remap[2:0] of the selected window.
- R8: When no window hits, the miss flag is 1, the output address equals the input address and the target is 0.
- R9: When several windows hit, the lowest-numbered one is used.
- R10: A register write becomes visible in translations and reads from the cycle after the write edge, and not before it.
- R11: Processor windows never affect DMA translation, and DMA windows never affect processor translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_off_i | input | 9 | Register byte offset |
| cfg_wdata_i | input | 64 | Write data |
| cfg_rdata_o | output | 64 | Read data for cfg_off_i, combinational |
| cpu_addr_i | input | 64 | Processor request address |
| cpu_addr_o | output | 64 | Translated processor address |
| cpu_tgt_o | output | 3 | Processor destination code |
| cpu_miss_o | output | 1 | No processor window hit |
| dma_addr_i | input | 64 | DMA request address |
| dma_addr_o | output | 64 | Translated DMA address |
| dma_tgt_o | output | 3 | DMA destination code |
| dma_miss_o | output | 1 | No DMA window hit |

## Verification
The hardest case to reach is priority between overlapping windows (R9). It only appears after two windows of one source are programmed to cover the same range with different sizes and different remap words. The stimulus sets up DMA window 0 (256 MiB, non-identity, with code bits set) and DMA window 1 (16 MiB inside it), then sends an address inside both. It then moves window 0 away, so the same address is served by window 1. A reference register shadow and a behavioural translator in the bench are compared on every clock. That comparison also covers the write cycle itself, which shows that a new value is not used before the edge.

// File: rtl/addrwin_pkg.sv
package addrwin_pkg;
  localparam int unsigned ADDR_W = 64;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] mmap;
  } win_cfg_t;

  localparam logic [ADDR_W-1:0] BOOT_SIZE = ADDR_W'(64'h1000_0000);
endpackage

// File: rtl/addrwin_regs.sv
module addrwin_regs
  import addrwin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned OFF_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [ADDR_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] rdata_o,
  output win_cfg_t          cpu_win_o [NUM_WIN],
  output win_cfg_t          dma_win_o [NUM_WIN]
);
  localparam int unsigned NREG  = 6 * NUM_WIN;
  localparam int unsigned IDX_W = OFF_W - 3;
  localparam logic [IDX_W-1:0] NREG_L = IDX_W'(NREG);

  logic [ADDR_W-1:0] reg_q [NREG];
  logic [IDX_W-1:0]  idx;
  logic              idx_ok;

  assign idx    = off_i[OFF_W-1:3];
  assign idx_ok = idx < NREG_L;

  // index = domain*3N + field*N + window; field 0 base, 1 mask, 2 mmap
  function automatic logic [ADDR_W-1:0] rst_val(int unsigned i);
    int unsigned dom, fld, w;
    dom = i / (3 * NUM_WIN);
    fld = (i % (3 * NUM_WIN)) / NUM_WIN;
    w   = i % NUM_WIN;
    if (dom == 0 && w < 2) begin
      case (fld)
        0:       return BOOT_SIZE * ADDR_W'(w);
        1:       return ~(BOOT_SIZE - 1'b1);
        default: return (BOOT_SIZE * ADDR_W'(w)) | ADDR_W'(w);
      endcase
    end
    return (fld == 2) ? '0 : '1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) reg_q[i] <= rst_val(i);
    end else if (wr_i && idx_ok) begin
      reg_q[idx] <= wdata_i;
    end
  end

  assign rdata_o = idx_ok ? reg_q[idx] : '0;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_out
    assign cpu_win_o[w].base = reg_q[w];
    assign cpu_win_o[w].mask = reg_q[NUM_WIN + w];
    assign cpu_win_o[w].mmap = reg_q[2*NUM_WIN + w];
    assign dma_win_o[w].base = reg_q[3*NUM_WIN + w];
    assign dma_win_o[w].mask = reg_q[4*NUM_WIN + w];
    assign dma_win_o[w].mmap = reg_q[5*NUM_WIN + w];
  end

  logic [NREG*ADDR_W-1:0] flat;
  always_comb begin
    for (int i = 0; i < NREG; i++) flat[i*ADDR_W +: ADDR_W] = reg_q[i];
  end

  a_r3_write_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_i && idx_ok) && off_i == $past(off_i)) |-> rdata_o == $past(wdata_i));

  a_r4_oob_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_i && !idx_ok) |-> $stable(flat));

  a_r4_oob_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (off_i >= OFF_W'(NREG * 8)) |-> rdata_o == '0);
endmodule

// File: rtl/addrwin_xlate.sv
module addrwin_xlate
  import addrwin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned CODE_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  win_cfg_t          win_i [NUM_WIN],
  output logic [ADDR_W-1:0] addr_o,
  output logic [CODE_W-1:0] tgt_o,
  output logic              miss_o
);
  localparam logic [ADDR_W-1:0] CODE_MSK = (ADDR_W'(1) << CODE_W) - 1'b1;
  localparam int unsigned SEL_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

  logic [NUM_WIN-1:0] hit;
  logic [SEL_W-1:0]   sel;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
    assign hit[w] = (addr_i & win_i[w].mask) == (win_i[w].base & win_i[w].mask);
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    sel = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit[w]) sel = SEL_W'(w);
    end
  end

  always_comb begin
    miss_o = ~|hit;
    if (miss_o) begin
      addr_o = addr_i;
      tgt_o  = '0;
    end else begin
      addr_o = (win_i[sel].mmap & win_i[sel].mask & ~CODE_MSK) | (addr_i & ~win_i[sel].mask);
      tgt_o  = win_i[sel].mmap[CODE_W-1:0];
    end
  end

  a_r8_miss_passthrough: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (addr_o == addr_i && tgt_o == '0));

  a_r5_miss_means_no_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == win_i[0].base) |-> !miss_o);
endmodule

// File: rtl/addrwin_remap.sv
module addrwin_remap
  import addrwin_pkg::*;
#(
  parameter int unsigned NUM_WIN = 4,
  parameter int unsigned CODE_W  = 3,
  parameter int unsigned OFF_W   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [OFF_W-1:0]  cfg_off_i,
  input  logic [63:0]       cfg_wdata_i,
  output logic [63:0]       cfg_rdata_o,
  input  logic [63:0]       cpu_addr_i,
  output logic [63:0]       cpu_addr_o,
  output logic [CODE_W-1:0] cpu_tgt_o,
  output logic              cpu_miss_o,
  input  logic [63:0]       dma_addr_i,
  output logic [63:0]       dma_addr_o,
  output logic [CODE_W-1:0] dma_tgt_o,
  output logic              dma_miss_o
);
  win_cfg_t cpu_win [NUM_WIN];
  win_cfg_t dma_win [NUM_WIN];

  addrwin_regs #(.NUM_WIN(NUM_WIN), .OFF_W(OFF_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (cfg_wr_i),
    .off_i     (cfg_off_i),
    .wdata_i   (cfg_wdata_i),
    .rdata_o   (cfg_rdata_o),
    .cpu_win_o (cpu_win),
    .dma_win_o (dma_win)
  );

  addrwin_xlate #(.NUM_WIN(NUM_WIN), .CODE_W(CODE_W)) u_cpu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (cpu_addr_i),
    .win_i  (cpu_win),
    .addr_o (cpu_addr_o),
    .tgt_o  (cpu_tgt_o),
    .miss_o (cpu_miss_o)
  );

  addrwin_xlate #(.NUM_WIN(NUM_WIN), .CODE_W(CODE_W)) u_dma (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (dma_addr_i),
    .win_i  (dma_win),
    .addr_o (dma_addr_o),
    .tgt_o  (dma_tgt_o),
    .miss_o (dma_miss_o)
  );

  // R11: a DMA write must leave processor translation of a fixed address unchanged
  a_r11_domain_isolation: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_wr_i && cfg_off_i >= 9'h060 && cfg_off_i < 9'h0C0) && $stable(cpu_addr_i))
    |-> $stable(cpu_addr_o));
endmodule

// File: tb/sim_addrwin_remap.sv
module sim_addrwin_remap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [8:0]  cfg_off = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic [63:0] cpu_addr = '0, cpu_addr_o;
  logic [2:0]  cpu_tgt;
  logic        cpu_miss;
  logic [63:0] dma_addr = '0, dma_addr_o;
  logic [2:0]  dma_tgt;
  logic        dma_miss;

  int checks = 0;
  int failures = 0;
  logic [63:0] sh [24];

  always #10 clk = ~clk;

  addrwin_remap u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(cfg_wr), .cfg_off_i(cfg_off),
    .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .cpu_addr_i(cpu_addr), .cpu_addr_o(cpu_addr_o), .cpu_tgt_o(cpu_tgt), .cpu_miss_o(cpu_miss),
    .dma_addr_i(dma_addr), .dma_addr_o(dma_addr_o), .dma_tgt_o(dma_tgt), .dma_miss_o(dma_miss)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural model: first matching window in index order
  task automatic model(int dom, logic [63:0] a, output logic [63:0] ao,
                       output logic [2:0] t, output logic m);
    ao = a; t = 3'd0; m = 1'b1;
    for (int w = 0; w < 4; w++) begin
      logic [63:0] b, k, p;
      b = sh[dom*12 + w]; k = sh[dom*12 + 4 + w]; p = sh[dom*12 + 8 + w];
      if (m && ((a & k) == (b & k))) begin
        ao = ({p[63:3], 3'b000} & k) | (a & ~k);
        t = p[2:0];
        m = 1'b0;
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [63:0] ea; logic [2:0] et; logic em;
      model(0, cpu_addr, ea, et, em);
      chk("R5 cpu addr", cpu_addr_o, ea);
      chk("R7 cpu tgt", {61'd0, cpu_tgt}, {61'd0, et});
      chk("R8 cpu miss", {63'd0, cpu_miss}, {63'd0, em});
      model(1, dma_addr, ea, et, em);
      chk("R5 dma addr", dma_addr_o, ea);
      chk("R7 dma tgt", {61'd0, dma_tgt}, {61'd0, et});
      chk("R8 dma miss", {63'd0, dma_miss}, {63'd0, em});
      chk("R3 rdata", cfg_rdata, (cfg_off < 9'h0C0) ? sh[cfg_off[8:3]] : 64'd0);
    end
  end

  task automatic wr(logic [8:0] off, logic [63:0] d);
    @(posedge clk); #2;
    cfg_wr = 1'b1; cfg_off = off; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
    if (off < 9'h0C0) sh[off[8:3]] = d;
  endtask

  task automatic rd(string tag, logic [8:0] off, logic [63:0] exp);
    @(posedge clk); #2;
    cfg_off = off;
    @(negedge clk);
    chk(tag, cfg_rdata, exp);
  endtask

  task automatic xl(string tag, logic [63:0] ca, logic [63:0] da,
                    logic [63:0] eca, logic [2:0] ect, logic ecm,
                    logic [63:0] eda, logic [2:0] edt, logic edm);
    @(posedge clk); #2;
    cpu_addr = ca; dma_addr = da;
    @(negedge clk);
    chk({tag, " cpu addr"}, cpu_addr_o, eca);
    chk({tag, " cpu tgt"}, {61'd0, cpu_tgt}, {61'd0, ect});
    chk({tag, " cpu miss"}, {63'd0, cpu_miss}, {63'd0, ecm});
    chk({tag, " dma addr"}, dma_addr_o, eda);
    chk({tag, " dma tgt"}, {61'd0, dma_tgt}, {61'd0, edt});
    chk({tag, " dma miss"}, {63'd0, dma_miss}, {63'd0, edm});
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog act=hang exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 24; i++) sh[i] = (i % 12 >= 8) ? 64'd0 : '1;
    sh[0] = 64'd0;           sh[1] = 64'h1000_0000;
    sh[4] = 64'hFFFF_FFFF_F000_0000; sh[5] = 64'hFFFF_FFFF_F000_0000;
    sh[8] = 64'd0;           sh[9] = 64'h1000_0001;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1 / R2 reset state
    rd("R1 cpu w0 mask", 9'h020, 64'hFFFF_FFFF_F000_0000);
    rd("R1 cpu w1 base", 9'h008, 64'h1000_0000);
    rd("R1 cpu w1 mmap", 9'h048, 64'h1000_0001);
    rd("R2 cpu w3 base", 9'h018, '1);
    rd("R2 dma w2 mask", 9'h090, '1);
    rd("R2 dma w0 mmap", 9'h0A0, 64'd0);
    xl("R1 boot ddr", 64'h0123_4567, 64'h0123_4567, 64'h0123_4567, 3'd0, 1'b0, 64'h0123_4567, 3'd0, 1'b1);
    xl("R1 boot pci", 64'h1800_0010, 64'h1800_0010, 64'h1800_0010, 3'd1, 1'b0, 64'h1800_0010, 3'd0, 1'b1);
    xl("R8 cpu miss", 64'h4000_0000, 64'h5555_0000, 64'h4000_0000, 3'd0, 1'b1, 64'h5555_0000, 3'd0, 1'b1);

    // R3 offsets and readback, R4 low bits ignored and out of range
    rd("R4 low bits ignored", 9'h04B, 64'h1000_0001);
    wr(9'h098, 64'hDEAD_BEEF_0000_0000);
    rd("R3 dma w3 mask", 9'h098, 64'hDEAD_BEEF_0000_0000);
    wr(9'h0C0, 64'h1234);
    rd("R4 oob read", 9'h0C0, 64'd0);
    wr(9'h178, 64'h5678);
    rd("R4 oob high", 9'h178, 64'd0);
    rd("R4 oob no alias", 9'h000, 64'd0);

    // R5/R6/R7 processor window 2 identity to peripheral bus
    wr(9'h010, 64'h4000_0000);
    wr(9'h030, 64'hFFFF_FFFF_C000_0000);
    wr(9'h050, 64'h4000_0001);
    xl("R6 cpu w2", 64'h5000_0004, 64'h5000_0004, 64'h5000_0004, 3'd1, 1'b0, 64'h5000_0004, 3'd0, 1'b1);

    // R6 non-identity DMA window 0 with code bits set; R11 processor unaffected
    wr(9'h080, 64'hFFFF_FFFF_F000_0000);
    wr(9'h0A0, 64'h8000_0007);
    // R10: window 0 base written while a matching address is applied
    @(posedge clk); #2;
    dma_addr = 64'h2345_6789;
    cfg_wr = 1'b1; cfg_off = 9'h060; cfg_wdata = 64'h2000_0000;
    @(negedge clk);
    chk("R10 not before edge", {63'd0, dma_miss}, 64'd1);
    @(posedge clk); #1;
    cfg_wr = 1'b0; sh[12] = 64'h2000_0000;
    @(negedge clk);
    chk("R10 after edge", dma_addr_o, 64'h8345_6789);
    xl("R6 R11 dma remap", 64'h2345_6789, 64'h2345_6789, 64'h2345_6789, 3'd0, 1'b1, 64'h8345_6789, 3'd7, 1'b0);

    // R9 priority between overlapping DMA windows
    wr(9'h068, 64'h2000_0000);
    wr(9'h088, 64'hFFFF_FFFF_FF00_0000);
    wr(9'h0A8, 64'h9000_0001);
    xl("R9 lowest wins", 64'h0, 64'h2012_3456, 64'h0, 3'd0, 1'b0, 64'h8012_3456, 3'd7, 1'b0);
    wr(9'h060, '1);
    xl("R9 next window", 64'h0, 64'h2012_3456, 64'h0, 3'd0, 1'b0, 64'h9012_3456, 3'd1, 1'b0);

    // sweep of mixed addresses against the model
    for (int i = 0; i < 64; i++) begin
      @(posedge clk); #2;
      cpu_addr = 64'(i) * 64'h0371_0000 + 64'h55;
      dma_addr = 64'h1F80_0000 + 64'(i) * 64'h0011_0000;
      cfg_off = 9'(i * 8);
    end
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule